// File: doc/BRIEF.md
# DRAM Leaf Strobe Steering Unit

This unit turns the phase reported by an upstream DRAM sequencer into the per-lane control strobes of a 32-bit DRAM array. The array may be built as one flat bank or as two interleaved leaves, one even and one odd. The unit drives eight active-low column strobes, one pair of active-low write enables, one active-low output enable per leaf and one active-high address latch enable per leaf. Every output is taken from a flop, so each output follows the inputs sampled at the previous rising edge.

In flat mode each byte enable is copied onto two column strobes, one in each half of the strobe bus. In interleaved mode the leaf-select input routes the four byte enables to the half of the strobe bus that belongs to the addressed leaf, and the other half stays idle. The same input selects which leaf gets its address latch enable and, on reads, its output enable. A refresh phase drops every column strobe at once.

The phase input uses this encoding: 0 idle, 1 row, 2 column, 3 data, 4 refresh. Codes 5 to 7 are unused and are treated as idle. The address is a valid column address during the column and data phases. An address of either kind is present during the row and column phases.

Top module: `dram_leaf_strobe`

## Requirements
- R1: In flat mode (`ilv_i`=0), during phase 2 or 3, `cas_n_o[k]` and `cas_n_o[k+4]` both equal `be_n_i[k]` for k=0..3, whatever `leaf_i` is.
- R2: In interleaved mode (`ilv_i`=1), during phase 2 or 3, the leaf addressed by `leaf_i` gets the byte enables on its strobe half (leaf 0 on `cas_n_o[3:0]`, leaf 1 on `cas_n_o[7:4]`), and the other half is all ones.
- R3: During phases 0, 1 and the unused codes 5 to 7, all eight column strobes are high.
- R4: During phase 4 (refresh), all eight column strobes are low, whatever the byte enables, mode, leaf select and read/write flag are.
- R5: `ale_o[leaf_i]` is 1 only in interleaved mode during phase 1 or 2. The other latch enable is 0 at that time, and both are 0 in every other case.
- R6: `leaf_oe_n_o[leaf_i]` is 0 only on an interleaved read (`wr_i`=0) during phase 2 or 3. The other leaf enable is 1 at that time, and both are 1 in every other case.
- R7: Both bits of `we_n_o` always carry the same value. They are 0 when `wr_i`=1 during phase 1, 2 or 3, and 1 in all other cases, including refresh.
- R8: In flat mode both leaf output enables stay 1 and both address latch enables stay 0, for every phase and every leaf select.
- R9: While `rst` is high at a rising edge, the outputs go to `cas_n_o`=8'hFF, `we_n_o`=2'b11, `leaf_oe_n_o`=2'b11 and `ale_o`=2'b00, whatever the other inputs are.
- R10: Each output changes only at a rising clock edge and shows the inputs sampled at that edge, a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_i | input | 3 | Sequencer phase code (0 idle, 1 row, 2 column, 3 data, 4 refresh) |
| be_n_i | input | 4 | Active-low byte enables, bit k for byte lane k |
| wr_i | input | 1 | 1 for a write access, 0 for a read access |
| leaf_i | input | 1 | Leaf select, 0 even and 1 odd |
| ilv_i | input | 1 | 1 selects interleaved mode, 0 selects flat mode |
| cas_n_o | output | 8 | Active-low column strobes |
| we_n_o | output | 2 | Active-low write enables, both copies identical |
| leaf_oe_n_o | output | 2 | Active-low per-leaf read output enables |
| ale_o | output | 2 | Active-high per-leaf address latch enables |

## Verification
Every cycle, the assertions check the properties that can be judged from the previous cycle's inputs alone. These are: the two strobe halves are identical in flat mode, the idle half is dark in interleaved mode, all strobes are high outside the column phases and all are low in refresh, at most one leaf enable and one latch enable is active at a time, the leaf controls stay quiet in flat mode, and the write-enable copies agree. The exact byte pattern on the active half, the choice of leaf, the one-cycle latency and the reset that overrides a refresh in progress can only be shown by the bench's vectors, which compare whole output words against values worked out by hand.

// File: rtl/dram_strobe_pkg.sv
package dram_strobe_pkg;

    // Geometry of the array
    localparam int LANES     = 4;
    localparam int LEAVES    = 2;
    localparam int WE_COPIES = 2;
    localparam int LEAF_W    = (LEAVES > 1) ? $clog2(LEAVES) : 1;
    localparam int STROBES   = LANES * LEAVES;
    localparam int PHASE_W   = 3;

    // Sequencer phase codes; codes above PH_REFRESH count as idle
    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE    = 3'd0,
        PH_ROW     = 3'd1,
        PH_COL     = 3'd2,
        PH_DATA    = 3'd3,
        PH_REFRESH = 3'd4
    } phase_e;

    // Registered output bundle
    typedef struct packed {
        logic [STROBES-1:0]   cas_n;
        logic [WE_COPIES-1:0] we_n;
        logic [LEAVES-1:0]    oe_n;
        logic [LEAVES-1:0]    ale;
    } strobe_t;

    localparam strobe_t STROBE_RESET = '{
        cas_n: '1,
        we_n:  '1,
        oe_n:  '1,
        ale:   '0
    };

    // Column address valid on the multiplexed bus
    function automatic logic ph_col_valid(input logic [PHASE_W-1:0] ph);
        return (ph == PH_COL) || (ph == PH_DATA);
    endfunction

    // Row or column address present on the multiplexed bus
    function automatic logic ph_addr_valid(input logic [PHASE_W-1:0] ph);
        return (ph == PH_ROW) || (ph == PH_COL);
    endfunction

    // Any phase of a normal read or write access
    function automatic logic ph_access(input logic [PHASE_W-1:0] ph);
        return (ph == PH_ROW) || (ph == PH_COL) || (ph == PH_DATA);
    endfunction

    function automatic logic ph_refresh(input logic [PHASE_W-1:0] ph);
        return ph == PH_REFRESH;
    endfunction

    // Leaf index comparison
    function automatic logic leaf_hit(input logic [LEAF_W-1:0] sel, input int idx);
        return sel == LEAF_W'(idx);
    endfunction

endpackage

// File: rtl/dls_cas_steer.sv
module dls_cas_steer
    import dram_strobe_pkg::*;
(
    input  logic [PHASE_W-1:0] phase_i,
    input  logic [LANES-1:0]   be_n_i,
    input  logic [LEAF_W-1:0]  leaf_i,
    input  logic               ilv_i,
    output logic [STROBES-1:0] cas_n_o
);

    // One strobe group per leaf. In flat mode every group carries the
    // byte enables; in interleaved mode only the addressed group does.
    for (genvar lf = 0; lf < LEAVES; lf++) begin : g_leaf
        logic group_sel;

        always_comb begin
            group_sel = !ilv_i || leaf_hit(leaf_i, lf);
        end

        always_comb begin
            if (ph_refresh(phase_i)) begin
                cas_n_o[lf*LANES +: LANES] = '0;
            end else if (!ph_col_valid(phase_i)) begin
                cas_n_o[lf*LANES +: LANES] = '1;
            end else if (group_sel) begin
                cas_n_o[lf*LANES +: LANES] = be_n_i;
            end else begin
                cas_n_o[lf*LANES +: LANES] = '1;
            end
        end
    end

endmodule

// File: rtl/dls_leaf_ctrl.sv
module dls_leaf_ctrl
    import dram_strobe_pkg::*;
(
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               wr_i,
    input  logic [LEAF_W-1:0]  leaf_i,
    input  logic               ilv_i,
    output logic [LEAVES-1:0]  oe_n_o,
    output logic [LEAVES-1:0]  ale_o
);

    logic latch_window;
    logic read_window;

    always_comb begin
        latch_window = ilv_i && ph_addr_valid(phase_i);
        read_window  = ilv_i && !wr_i && ph_col_valid(phase_i);
    end

    for (genvar lf = 0; lf < LEAVES; lf++) begin : g_leaf
        always_comb begin
            ale_o[lf]  = latch_window && leaf_hit(leaf_i, lf);
            oe_n_o[lf] = !(read_window && leaf_hit(leaf_i, lf));
        end
    end

endmodule

// File: rtl/dls_we_drive.sv
module dls_we_drive
    import dram_strobe_pkg::*;
(
    input  logic [PHASE_W-1:0]   phase_i,
    input  logic                 wr_i,
    output logic [WE_COPIES-1:0] we_n_o
);

    logic we_act;

    always_comb begin
        we_act = wr_i && ph_access(phase_i);
    end

    // Replicated copies for load sharing
    for (genvar k = 0; k < WE_COPIES; k++) begin : g_copy
        always_comb begin
            we_n_o[k] = !we_act;
        end
    end

endmodule

// File: rtl/dram_leaf_strobe.sv
module dram_leaf_strobe
    import dram_strobe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  phase_i,
    input  logic [3:0]  be_n_i,
    input  logic        wr_i,
    input  logic        leaf_i,
    input  logic        ilv_i,
    output logic [7:0]  cas_n_o,
    output logic [1:0]  we_n_o,
    output logic [1:0]  leaf_oe_n_o,
    output logic [1:0]  ale_o
);

    strobe_t nxt;
    strobe_t q;

    dls_cas_steer u_cas (
        .phase_i (phase_i),
        .be_n_i  (be_n_i),
        .leaf_i  (leaf_i),
        .ilv_i   (ilv_i),
        .cas_n_o (nxt.cas_n)
    );

    dls_leaf_ctrl u_leaf (
        .phase_i (phase_i),
        .wr_i    (wr_i),
        .leaf_i  (leaf_i),
        .ilv_i   (ilv_i),
        .oe_n_o  (nxt.oe_n),
        .ale_o   (nxt.ale)
    );

    dls_we_drive u_we (
        .phase_i (phase_i),
        .wr_i    (wr_i),
        .we_n_o  (nxt.we_n)
    );

    // Output register: every pin leaves from a flop
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= STROBE_RESET;
        end else begin
            q <= nxt;
        end
    end

    assign cas_n_o     = q.cas_n;
    assign we_n_o      = q.we_n;
    assign leaf_oe_n_o = q.oe_n;
    assign ale_o       = q.ale;

    // Marks cycles whose outputs came from sampled inputs, not from reset
    logic live;
    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    AST_FLAT_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (live && !$past(ilv_i)) |-> (cas_n_o[3:0] == cas_n_o[7:4])); // R1

    AST_ILV_HALF_DARK: assert property (@(posedge clk) disable iff (rst)
        (live && $past(ilv_i) && ph_col_valid($past(phase_i)))
        |-> (($past(leaf_i) ? cas_n_o[3:0] : cas_n_o[7:4]) == 4'hF)); // R2

    AST_CAS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (live && !ph_col_valid($past(phase_i)) && !ph_refresh($past(phase_i)))
        |-> (cas_n_o == 8'hFF)); // R3

    AST_REFRESH_ALL: assert property (@(posedge clk) disable iff (rst)
        (live && ph_refresh($past(phase_i))) |-> (cas_n_o == 8'h00)); // R4

    AST_ALE_ONE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ale_o)); // R5

    AST_OE_ONE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~leaf_oe_n_o)); // R6

    AST_OE_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (live && $past(wr_i)) |-> (leaf_oe_n_o == 2'b11)); // R6

    AST_WE_COPIES: assert property (@(posedge clk) disable iff (rst)
        we_n_o[0] == we_n_o[1]); // R7

    AST_WE_REFRESH: assert property (@(posedge clk) disable iff (rst)
        (live && ph_refresh($past(phase_i))) |-> (we_n_o == 2'b11)); // R7

    AST_FLAT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (live && !$past(ilv_i)) |-> (leaf_oe_n_o == 2'b11 && ale_o == 2'b00)); // R8

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (cas_n_o == 8'hFF && we_n_o == 2'b11 &&
                        leaf_oe_n_o == 2'b11 && ale_o == 2'b00)); // R9

endmodule

// File: tb/dram_leaf_strobe_bench.sv
module dram_leaf_strobe_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] phase_i = 3'd0;
    logic [3:0] be_n_i = 4'hF;
    logic       wr_i = 1'b0;
    logic       leaf_i = 1'b0;
    logic       ilv_i = 1'b0;
    logic [7:0] cas_n_o;
    logic [1:0] we_n_o;
    logic [1:0] leaf_oe_n_o;
    logic [1:0] ale_o;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk; // 50 MHz

    dram_leaf_strobe u_dram_leaf_strobe (
        .clk         (clk),
        .rst         (rst),
        .phase_i     (phase_i),
        .be_n_i      (be_n_i),
        .wr_i        (wr_i),
        .leaf_i      (leaf_i),
        .ilv_i       (ilv_i),
        .cas_n_o     (cas_n_o),
        .we_n_o      (we_n_o),
        .leaf_oe_n_o (leaf_oe_n_o),
        .ale_o       (ale_o)
    );

    // Vector: phase, be_n, wr, leaf, ilv | cas_n, we_n, oe_n, ale
    localparam int NV = 16;
    localparam logic [23:0] VEC [NV] = '{
        {3'd2, 4'b0000, 1'b0, 1'b0, 1'b0, 8'h00, 2'b11, 2'b11, 2'b00},
        {3'd3, 4'b1010, 1'b1, 1'b0, 1'b0, 8'hAA, 2'b00, 2'b11, 2'b00},
        {3'd2, 4'b0110, 1'b0, 1'b1, 1'b0, 8'h66, 2'b11, 2'b11, 2'b00},
        {3'd2, 4'b0101, 1'b0, 1'b0, 1'b1, 8'hF5, 2'b11, 2'b10, 2'b01},
        {3'd2, 4'b0011, 1'b0, 1'b1, 1'b1, 8'h3F, 2'b11, 2'b01, 2'b10},
        {3'd3, 4'b1100, 1'b1, 1'b1, 1'b1, 8'hCF, 2'b00, 2'b11, 2'b00},
        {3'd3, 4'b0000, 1'b0, 1'b0, 1'b1, 8'hF0, 2'b11, 2'b10, 2'b00},
        {3'd1, 4'b0000, 1'b1, 1'b0, 1'b1, 8'hFF, 2'b00, 2'b11, 2'b01},
        {3'd1, 4'b0000, 1'b0, 1'b1, 1'b1, 8'hFF, 2'b11, 2'b11, 2'b10},
        {3'd1, 4'b0000, 1'b1, 1'b0, 1'b0, 8'hFF, 2'b00, 2'b11, 2'b00},
        {3'd4, 4'b1111, 1'b1, 1'b1, 1'b1, 8'h00, 2'b11, 2'b11, 2'b00},
        {3'd4, 4'b0101, 1'b0, 1'b0, 1'b0, 8'h00, 2'b11, 2'b11, 2'b00},
        {3'd0, 4'b0000, 1'b1, 1'b0, 1'b1, 8'hFF, 2'b11, 2'b11, 2'b00},
        {3'd5, 4'b0000, 1'b1, 1'b0, 1'b1, 8'hFF, 2'b11, 2'b11, 2'b00},
        {3'd7, 4'b0000, 1'b0, 1'b0, 1'b0, 8'hFF, 2'b11, 2'b11, 2'b00},
        {3'd2, 4'b1111, 1'b1, 1'b0, 1'b1, 8'hFF, 2'b00, 2'b11, 2'b01}
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [23:0] v);
        phase_i = v[23:21];
        be_n_i  = v[20:17];
        wr_i    = v[16];
        leaf_i  = v[15];
        ilv_i   = v[14];
    endtask

    task automatic check_vec(input logic [23:0] v);
        string rq_cas;
        string rq_ctl;
        if (v[23:21] == 3'd4)                               rq_cas = "R4";
        else if (v[23:21] != 3'd2 && v[23:21] != 3'd3)      rq_cas = "R3";
        else if (v[14])                                     rq_cas = "R2";
        else                                                rq_cas = "R1";
        rq_ctl = v[14] ? "R5/R6" : "R8";
        check(rq_cas, "cas_n", cas_n_o, v[13:6]);
        check("R7", "we_n", {6'd0, we_n_o}, {6'd0, v[5:4]});
        check(rq_ctl, "leaf_oe_n", {6'd0, leaf_oe_n_o}, {6'd0, v[3:2]});
        check(rq_ctl, "ale", {6'd0, ale_o}, {6'd0, v[1:0]});
    endtask

    initial begin : watchdog
        #(20 * 5000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9", "cas_n reset", cas_n_o, 8'hFF);
        check("R9", "we_n reset", {6'd0, we_n_o}, 8'h03);
        check("R9", "oe_n reset", {6'd0, leaf_oe_n_o}, 8'h03);
        check("R9", "ale reset", {6'd0, ale_o}, 8'h00);
        rst = 1'b0;

        // Table walk: drive at negedge, result visible after next posedge
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            @(negedge clk);
            check_vec(VEC[i]);
        end

        // R10: outputs hold until the rising edge, then update
        apply(VEC[0]);
        @(negedge clk);
        apply(VEC[4]);
        #5;
        check("R10", "cas_n before edge", cas_n_o, VEC[0][13:6]);
        @(negedge clk);
        check("R10", "cas_n after edge", cas_n_o, VEC[4][13:6]);
        check("R10", "ale after edge", {6'd0, ale_o}, {6'd0, VEC[4][1:0]});

        // R9: reset wins over a refresh and over an interleaved read
        apply(VEC[10]);
        rst = 1'b1;
        @(negedge clk);
        check("R9", "cas_n reset over refresh", cas_n_o, 8'hFF);
        apply(VEC[6]);
        @(negedge clk);
        check("R9", "oe_n reset over read", {6'd0, leaf_oe_n_o}, 8'h03);
        check("R9", "ale reset over read", {6'd0, ale_o}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check_vec(VEC[6]);

        // R4: refresh with all byte enables inactive, flat mode
        apply({3'd4, 4'b1111, 1'b0, 1'b1, 1'b0, 8'h00, 2'b11, 2'b11, 2'b00});
        @(negedge clk);
        check("R4", "cas_n refresh be off", cas_n_o, 8'h00);

        // R8: flat mode with odd leaf and a read in column phase
        apply({3'd2, 4'b1001, 1'b0, 1'b1, 1'b0, 8'h99, 2'b11, 2'b11, 2'b00});
        @(negedge clk);
        check("R8", "oe_n flat", {6'd0, leaf_oe_n_o}, 8'h03);
        check("R1", "cas_n flat odd", cas_n_o, 8'h99);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule